// File: doc/BRIEF.md
# Loopback and Duplex Mode Controller

This block sits between the MAC-side serial receive interface and the line-side receive path of a 10 Mb/s twisted-pair transceiver. It decides, cycle by cycle, whether the MAC sees its own transmit stream echoed back or the data recovered from the line. It also drives the enables for collision detection and for the SQE test.

Two active-low selection pins pick the operating mode. Both pins pass through a two-stage synchronizer before they are decoded. The decoded mode is one of three:

- **Standard loopback** (the default). The transmit stream is echoed while the MAC transmits. The echo drops out in any cycle that shows a collision, a link failure or jabber.
- **Forced internal loopback.** The transmit stream is always returned, and the line is ignored entirely.
- **External loopback with full duplex.** No internal echo is made, and collision detection and SQE are switched off.

The receive outputs are registered. They reflect the inputs of the previous clock.

Top module: `lb_duplex_ctrl`

## Requirements
- R1: During and directly after reset, rx_valid is 0 and rx_data is 0. The mode is standard loopback, so col_det_en=1, sqe_en=1 and full_duplex=0.
- R2: Standard mode is selected by loop_sel_n=1 and duplex_sel_n=1. In this mode, a cycle with tx_en=1 and no collision, link fail or jabber gives rx_valid=1 and rx_data=tx_data on the next clock.
- R3: In standard mode, a cycle with col_in=1 makes the next-clock rx_valid equal line_valid, and rx_data equal line_data, even while tx_en=1.
- R4: In standard mode, link_fail=1 or jabber=1 in a cycle routes the line to the receive outputs on the next clock, even while tx_en=1.
- R5: Forced mode is selected by loop_sel_n=0 and duplex_sel_n=1. In this mode, the next-clock rx_valid equals tx_en and rx_data equals tx_data, whatever line_valid, line_data, col_in, link_fail and jabber are. With tx_en=0, rx_valid is 0 even if line_valid=1.
- R6: External/full-duplex mode is selected by loop_sel_n=0 and duplex_sel_n=0. In this mode, full_duplex=1, col_det_en=0 and sqe_en=0, and the receive outputs carry the line even while tx_en=1.
- R7: The unused encoding (loop_sel_n=1, duplex_sel_n=0) behaves exactly like standard mode, in both the enables and the data path.
- R8: A change on the selection pins reaches col_det_en, sqe_en and full_duplex on the second rising clock edge after the change, and not on the first.
- R9: When no loopback is active and line_valid=0, the next-clock rx_valid is 0 and rx_data is 0. Whenever rx_valid is 0, rx_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_sel_n | input | 1 | Active-low loopback selection pin (asynchronous) |
| duplex_sel_n | input | 1 | Active-low duplex selection pin (asynchronous) |
| tx_en | input | 1 | MAC transmit enable |
| tx_data | input | DATA_W | MAC transmit data |
| line_valid | input | 1 | Line receive data present |
| line_data | input | DATA_W | Line receive data |
| col_in | input | 1 | Collision status |
| link_fail | input | 1 | Link failure status |
| jabber | input | 1 | Jabber status |
| rx_valid | output | 1 | Receive valid toward the MAC |
| rx_data | output | DATA_W | Receive data toward the MAC |
| col_det_en | output | 1 | Collision detection enable |
| sqe_en | output | 1 | SQE test enable |
| full_duplex | output | 1 | Full-duplex indication |

## Verification
The interesting overlap is a transmit beat that lands in the same cycle as a collision, link failure or jabber. The echo and the line path then both want the receive outputs. The bench raises each fault together with tx_en, while the line carries a pattern distinct from the transmit data. Its scoreboard then expects the line pattern one clock later in standard mode, and the transmit pattern in forced mode. A second overlap is a pin change landing while beats flow. This is judged by sampling the enables after the first and after the second edge.

// File: rtl/lbdx_pkg.sv
package lbdx_pkg;

    typedef enum logic [1:0] {
        LB_STANDARD = 2'd0,
        LB_FORCED   = 2'd1,
        LB_EXTERNAL = 2'd2
    } lb_mode_e;

    typedef struct packed {
        logic col_det_en;
        logic sqe_en;
        logic full_duplex;
        logic loop_gated;   // echo allowed when transmitting and fault-free
        logic loop_forced;  // echo unconditionally, line ignored
    } lb_ctrl_t;

    // pins = {loop_sel_n, duplex_sel_n}, both active low
    function automatic lb_mode_e decode_mode(input logic [1:0] pins);
        case (pins)
            2'b01:   return LB_FORCED;
            2'b00:   return LB_EXTERNAL;
            default: return LB_STANDARD;  // 2'b11 and the unused 2'b10
        endcase
    endfunction

    function automatic lb_ctrl_t ctrl_of(input lb_mode_e m);
        lb_ctrl_t c;
        c.col_det_en  = (m != LB_EXTERNAL);
        c.sqe_en      = (m != LB_EXTERNAL);
        c.full_duplex = (m == LB_EXTERNAL);
        c.loop_gated  = (m == LB_STANDARD);
        c.loop_forced = (m == LB_FORCED);
        return c;
    endfunction

endpackage

// File: rtl/lb_pin_sync.sv
module lb_pin_sync #(
    parameter int          STAGES    = 2,
    parameter int          W         = 2,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= RESET_VAL;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lb_path_sel.sv
module lb_path_sel
    import lbdx_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  lb_ctrl_t          ctrl,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_data,
    input  logic              col_in,
    input  logic              link_fail,
    input  logic              jabber,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    logic              fault;
    logic              echo_std;
    logic              nxt_valid;
    logic [DATA_W-1:0] nxt_data;

    assign fault    = col_in | link_fail | jabber;
    assign echo_std = ctrl.loop_gated & tx_en & ~fault;

    always_comb begin
        if (ctrl.loop_forced) begin
            nxt_valid = tx_en;
            nxt_data  = tx_en ? tx_data : '0;
        end else if (echo_std) begin
            nxt_valid = 1'b1;
            nxt_data  = tx_data;
        end else begin
            nxt_valid = line_valid;
            nxt_data  = line_valid ? line_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= nxt_valid;
            rx_data  <= nxt_data;
        end
    end
endmodule

// File: rtl/lb_duplex_ctrl.sv
module lb_duplex_ctrl
    import lbdx_pkg::*;
#(
    parameter int DATA_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_sel_n,
    input  logic              duplex_sel_n,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_data,
    input  logic              col_in,
    input  logic              link_fail,
    input  logic              jabber,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              col_det_en,
    output logic              sqe_en,
    output logic              full_duplex
);
    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pins_s;
    lb_mode_e         mode_q;
    lb_ctrl_t         ctrl;

    lb_pin_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RESET_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({loop_sel_n, duplex_sel_n}),
        .q   (pins_s)
    );

    assign mode_q = decode_mode(pins_s);
    assign ctrl   = ctrl_of(mode_q);

    assign col_det_en  = ctrl.col_det_en;
    assign sqe_en      = ctrl.sqe_en;
    assign full_duplex = ctrl.full_duplex;

    lb_path_sel #(.DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .tx_en      (tx_en),
        .tx_data    (tx_data),
        .line_valid (line_valid),
        .line_data  (line_data),
        .col_in     (col_in),
        .link_fail  (link_fail),
        .jabber     (jabber),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );
endmodule

// File: rtl/lb_duplex_ctrl_chk.sv
module lb_duplex_ctrl_chk
    import lbdx_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input logic              clk,
    input logic              rst,
    input lb_mode_e          mode_q,
    input logic              tx_en,
    input logic [DATA_W-1:0] tx_data,
    input logic              line_valid,
    input logic [DATA_W-1:0] line_data,
    input logic              col_in,
    input logic              link_fail,
    input logic              jabber,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              col_det_en,
    input logic              sqe_en,
    input logic              full_duplex
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_valid && rx_data == '0));

    assert_std_echo_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LB_STANDARD && tx_en && !col_in && !link_fail && !jabber)
        |=> (rx_valid && rx_data == $past(tx_data)));

    assert_col_line_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LB_STANDARD && col_in)
        |=> (rx_valid == $past(line_valid)
             && (!$past(line_valid) || rx_data == $past(line_data))));

    assert_forced_tx_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LB_FORCED)
        |=> (rx_valid == $past(tx_en)
             && (!$past(tx_en) || rx_data == $past(tx_data))));

    assert_ext_no_echo_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LB_EXTERNAL && !line_valid) |=> !rx_valid);

    assert_ext_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        full_duplex |-> (!col_det_en && !sqe_en));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> (rx_data == '0));
endmodule

bind lb_duplex_ctrl lb_duplex_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .mode_q(mode_q), .tx_en(tx_en), .tx_data(tx_data),
    .line_valid(line_valid), .line_data(line_data), .col_in(col_in),
    .link_fail(link_fail), .jabber(jabber), .rx_valid(rx_valid),
    .rx_data(rx_data), .col_det_en(col_det_en), .sqe_en(sqe_en),
    .full_duplex(full_duplex)
);

// File: tb/lb_duplex_ctrl_tb_top.sv
module lb_duplex_ctrl_tb_top;
    localparam int DW = 1;
    localparam int M_STD = 0, M_FRC = 1, M_EXT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic loop_sel_n = 1'b1, duplex_sel_n = 1'b1;
    logic tx_en = 1'b0, line_valid = 1'b0;
    logic [DW-1:0] tx_data = '0, line_data = '0;
    logic col_in = 1'b0, link_fail = 1'b0, jabber = 1'b0;
    logic rx_valid, col_det_en, sqe_en, full_duplex;
    logic [DW-1:0] rx_data;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;  // 125 MHz

    lb_duplex_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .loop_sel_n(loop_sel_n), .duplex_sel_n(duplex_sel_n),
        .tx_en(tx_en), .tx_data(tx_data), .line_valid(line_valid),
        .line_data(line_data), .col_in(col_in), .link_fail(link_fail),
        .jabber(jabber), .rx_valid(rx_valid), .rx_data(rx_data),
        .col_det_en(col_det_en), .sqe_en(sqe_en), .full_duplex(full_duplex)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_en(input string tag, input logic c, input logic s, input logic f);
        chk(tag, {5'd0, col_det_en, sqe_en, full_duplex}, {5'd0, c, s, f});
    endtask

    // Driver: apply one beat, push what the requirements predict for the next edge.
    task automatic beat(input int mode, input logic te, input logic [DW-1:0] td,
                        input logic lv, input logic [DW-1:0] ld,
                        input logic c, input logic lf, input logic jb, input string tag);
        exp_t e;
        @(negedge clk);
        tx_en = te; tx_data = td; line_valid = lv; line_data = ld;
        col_in = c; link_fail = lf; jabber = jb;
        e.tag = tag;
        if (mode == M_FRC) begin
            e.v = te; e.d = te ? td : '0;
        end else if (mode == M_STD && te && !c && !lf && !jb) begin
            e.v = 1'b1; e.d = td;
        end else begin
            e.v = lv; e.d = lv ? ld : '0;
        end
        sb.push_back(e);
    endtask

    // Monitor: compare away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " rx"}, {6'd0, rx_valid, rx_data}, {6'd0, e.v, e.d});
            end
        end
    end

    // Change pins, check the two-edge latency (R8) on the enables.
    task automatic set_mode(input logic ln, input logic dn, input logic c, input logic s,
                            input logic f, input string tag);
        logic oc, os, of;
        @(negedge clk);
        oc = col_det_en; os = sqe_en; of = full_duplex;
        loop_sel_n = ln; duplex_sel_n = dn;
        tx_en = 1'b0; line_valid = 1'b0; col_in = 1'b0; link_fail = 1'b0; jabber = 1'b0;
        @(posedge clk); #2;
        chk("R8 first edge unchanged", {5'd0, col_det_en, sqe_en, full_duplex}, {5'd0, oc, os, of});
        @(posedge clk); #2;
        chk_en({tag, " R8 second edge"}, c, s, f);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset rx", {6'd0, rx_valid, rx_data}, 8'd0);
        chk_en("R1 reset enables", 1'b1, 1'b1, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        chk("R1 after reset rx", {6'd0, rx_valid, rx_data}, 8'd0);
        chk_en("R1 after reset enables", 1'b1, 1'b1, 1'b0);

        // Standard
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 0, 0, "R2 echo 1");
        beat(M_STD, 1, 1'b0, 1, 1'b1, 0, 0, 0, "R2 echo 0");
        beat(M_STD, 1, 1'b1, 0, 1'b0, 0, 0, 0, "R2 echo no line");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 1, 0, 0, "R3 col with tx");
        beat(M_STD, 1, 1'b0, 1, 1'b1, 1, 0, 0, "R3 col line 1");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 1, 0, "R4 link fail");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 0, 1, "R4 jabber");
        beat(M_STD, 1, 1'b1, 0, 1'b0, 0, 1, 0, "R9 link fail no line");
        beat(M_STD, 0, 1'b1, 1, 1'b1, 0, 0, 0, "R2 idle tx line");
        beat(M_STD, 0, 1'b1, 0, 1'b1, 0, 0, 0, "R9 nothing");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 0, 0, "R2 echo again");
        @(posedge clk); #3;

        // Unused encoding
        set_mode(1'b1, 1'b0, 1, 1, 0, "R7 enables");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 0, 0, "R7 echo");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 1, 0, 0, "R7 col line");
        @(posedge clk); #3;

        // Forced
        set_mode(1'b0, 1'b1, 1, 1, 0, "R5 enables");
        beat(M_FRC, 1, 1'b1, 1, 1'b0, 1, 0, 0, "R5 col ignored");
        beat(M_FRC, 1, 1'b0, 1, 1'b1, 0, 1, 0, "R5 link fail ignored");
        beat(M_FRC, 1, 1'b1, 1, 1'b0, 0, 0, 1, "R5 jabber ignored");
        beat(M_FRC, 0, 1'b1, 1, 1'b1, 0, 0, 0, "R5 line ignored");
        beat(M_FRC, 1, 1'b1, 0, 1'b0, 0, 0, 0, "R5 echo");
        @(posedge clk); #3;

        // External / full duplex
        set_mode(1'b0, 1'b0, 0, 0, 1, "R6 enables");
        beat(M_EXT, 1, 1'b1, 1, 1'b0, 0, 0, 0, "R6 line over tx");
        beat(M_EXT, 1, 1'b0, 1, 1'b1, 0, 0, 0, "R6 line 1");
        beat(M_EXT, 1, 1'b1, 0, 1'b0, 0, 0, 0, "R9 ext no line");
        @(posedge clk); #3;

        // Back to standard
        set_mode(1'b1, 1'b1, 1, 1, 0, "R2 enables");
        beat(M_STD, 1, 1'b1, 1, 1'b0, 0, 0, 0, "R2 echo restored");
        @(posedge clk); @(posedge clk); #3;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule